// File: doc/BRIEF.md
# Edge-Triggered Control Port

This block is a write-only control register of configurable width, split into byte lanes that can be written independently. It keeps the last value written into each lane. A small set of action bits produce single-cycle pulses, and those pulses fire only when a write moves the bit from 0 to 1. A second set of bits is driven straight out as steady levels. In the default build the three actions clear two trackball position counters and reset a slave processor, and the two levels drive two coin-counter meters.

Software toggles an action bit to 0 and back to 1 to fire the action again. Writing 1 over a bit that already holds 1 does nothing. An action is seen only when the byte lane that contains its bit is enabled in that write. Address decoding and the devices that use the outputs sit outside this block.

Top module: `ctl_edge_port`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, all action pulses and level outputs are 0. The stored value resets to all zeros, so a first write of 1 to an action bit counts as a rising edge.
- R2: On an accepted write (wr_en=1), each byte lane whose enable bit is set (wr_be[k] covers data bits 8k+7..8k) takes the new data. Lanes that are not enabled keep their stored contents. Nothing changes when wr_en is 0.
- R3: act_pulse[0] goes high in the cycle after an accepted write that moves data bit 0 from 0 to 1 with lane 0 enabled. This pulse clears trackball counter 0.
- R4: act_pulse[1] goes high in the cycle after an accepted write that moves data bit 1 from 0 to 1 with lane 0 enabled. This pulse clears trackball counter 1.
- R5: act_pulse[2] is the slave-reset pulse. It goes high in the cycle after an accepted write that moves data bit 13 from 0 to 1 with lane 1 enabled.
- R6: Writing 1 to an action bit whose stored value is already 1 produces no pulse.
- R7: An action bit carried in a lane whose enable is clear produces no pulse, whatever its data value.
- R8: lvl_out[0] follows stored bit 15 and lvl_out[1] follows stored bit 14, both active high. They change only on writes that enable lane 1.
- R9: Every action pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; write is accepted at the rising edge |
| wr_be | input | 2 | Byte-lane enables, bit k covers data bits 8k+7..8k |
| wr_data | input | 16 | Write data |
| act_pulse | output | 3 | Action pulses: [0] clear counter 0, [1] clear counter 1, [2] slave reset |
| lvl_out | output | 2 | Level outputs: [0] coin counter 0, [1] coin counter 1 |

## Verification
The bench builds the block with its default parameters: a 16-bit word in two lanes, actions on bits 0, 1 and 13, and active-high levels on bits 15 and 14. With this layout every action sits in a known lane. Writes with only one lane enabled can therefore show both lane gating and lane preservation at the pulse outputs. Both clear actions share the low lane, so a single write with both bits set shows each edge detected independently. The slave-reset bit shares the high lane with the level bits, so the bench can test that pulsing and level updates do not interfere.

// File: rtl/ctl_edge_pkg.sv
package ctl_edge_pkg;
   localparam int unsigned LANE_W = 8;

   function automatic int unsigned lane_of(input int unsigned bit_pos);
      return bit_pos / LANE_W;
   endfunction
endpackage

// File: rtl/ctl_lane_store.sv
module ctl_lane_store #(
   parameter int unsigned DATA_W = 16
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         wr_en,
   input  logic [DATA_W/ctl_edge_pkg::LANE_W-1:0]       wr_be,
   input  logic [DATA_W-1:0]                            wr_data,
   output logic [DATA_W-1:0]                            q
);
   import ctl_edge_pkg::*;
   localparam int unsigned LANES = DATA_W / LANE_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[l*LANE_W +: LANE_W] <= '0;
         else if (wr_en && wr_be[l])
            q[l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end

      // R2: a lane left out of the write keeps its contents
      assert_lane_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_be[l]) |=> $stable(q[l*LANE_W +: LANE_W]));
   end
endmodule

// File: rtl/ctl_rise_cell.sv
module ctl_rise_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic lane_en,
   input  logic din,
   input  logic prev,
   output logic pulse
);
   logic rise;
   assign rise = wr_en && lane_en && din && !prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= rise;
   end

   // R9: never two consecutive pulse cycles
   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
   // R7: a pulse needs an enabled lane carrying a 1 in the previous cycle
   assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(wr_en && lane_en && din));
   // R6: a bit already set does not pulse again
   assert_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> !$past(prev));
endmodule

// File: rtl/ctl_level_tap.sv
module ctl_level_tap #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic lane_en,
   input  logic stored,
   output logic lvl
);
   if (ACTIVE_LOW) begin : g_low
      assign lvl = !stored;
   end else begin : g_high
      assign lvl = stored;
   end

   // R8: level moves only after a write on its own lane
   assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && lane_en) |=> $stable(lvl));
endmodule

// File: rtl/ctl_edge_port.sv
module ctl_edge_port #(
   parameter int unsigned DATA_W              = 16,
   parameter int unsigned NUM_ACT             = 3,
   parameter int unsigned ACT_POS [NUM_ACT]   = '{0, 1, 13},
   parameter int unsigned NUM_LVL             = 2,
   parameter int unsigned LVL_POS [NUM_LVL]   = '{15, 14},
   parameter bit          LVL_ACTIVE_LOW      = 1'b0
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [DATA_W/ctl_edge_pkg::LANE_W-1:0] wr_be,
   input  logic [DATA_W-1:0]                      wr_data,
   output logic [NUM_ACT-1:0]                     act_pulse,
   output logic [NUM_LVL-1:0]                     lvl_out
);
   import ctl_edge_pkg::*;
   localparam int unsigned LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0 || DATA_W == 0) begin : g_bad_width
      $error("ctl_edge_port: DATA_W must be a nonzero multiple of the lane width");
   end

   logic [DATA_W-1:0] store_q;

   ctl_lane_store #(.DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .q       (store_q)
   );

   for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
      localparam int unsigned P = ACT_POS[i];
      localparam int unsigned L = lane_of(P);
      if (P >= DATA_W) begin : g_bad_pos
         $error("ctl_edge_port: action bit position out of range");
      end
      ctl_rise_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .lane_en (wr_be[L]),
         .din     (wr_data[P]),
         .prev    (store_q[P]),
         .pulse   (act_pulse[i])
      );
   end

   for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
      localparam int unsigned P = LVL_POS[j];
      localparam int unsigned L = lane_of(P);
      if (P >= DATA_W) begin : g_bad_pos
         $error("ctl_edge_port: level bit position out of range");
      end
      ctl_level_tap #(.ACTIVE_LOW(LVL_ACTIVE_LOW)) u_tap (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .lane_en (wr_be[L]),
         .stored  (store_q[P]),
         .lvl     (lvl_out[j])
      );
   end

   // R2: without a write strobe the whole stored word holds
   assert_store_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(store_q));
   // R9: pulses are only launched by a write one cycle earlier
   assert_pulse_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|act_pulse) |-> $past(wr_en));
endmodule

// File: tb/sim_ctl_edge_port.sv
module sim_ctl_edge_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_be = 2'b00;
   logic [15:0] wr_data = 16'h0000;
   logic [2:0]  act_pulse;
   logic [1:0]  lvl_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ctl_edge_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_be     (wr_be),
      .wr_data   (wr_data),
      .act_pulse (act_pulse),
      .lvl_out   (lvl_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one accepted write; outputs checked in the cycle after, then pulse drop
   task automatic wr(input logic [1:0] be, input logic [15:0] d,
                     input logic [2:0] exp_act, input logic [1:0] exp_lvl, input string req);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      check({req, " pulses"}, {5'd0, act_pulse}, {5'd0, exp_act});
      check({req, " levels"}, {6'd0, lvl_out}, {6'd0, exp_lvl});
      @(negedge clk);
      check("R9 pulse width", {5'd0, act_pulse}, 8'd0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 pulses in reset", {5'd0, act_pulse}, 8'd0);
      check("R1 levels in reset", {6'd0, lvl_out}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pulses after reset", {5'd0, act_pulse}, 8'd0);
   endtask

   task automatic t_low_lane;
      wr(2'b01, 16'h0001, 3'b001, 2'b00, "R3 R1 first write edge");
      wr(2'b01, 16'h0001, 3'b000, 2'b00, "R6 repeat bit0");
      wr(2'b01, 16'h0000, 3'b000, 2'b00, "R3 clear bit0");
      wr(2'b01, 16'h0003, 3'b011, 2'b00, "R4 both clears");
      wr(2'b01, 16'h0000, 3'b000, 2'b00, "R4 clear low");
   endtask

   task automatic t_lane_gate;
      wr(2'b10, 16'h00FF, 3'b000, 2'b00, "R7 low data, high lane only");
      wr(2'b01, 16'h0001, 3'b001, 2'b00, "R2 low lane kept");
   endtask

   task automatic t_slave_reset;
      wr(2'b10, 16'h2000, 3'b100, 2'b00, "R5 slave reset");
      wr(2'b10, 16'h2000, 3'b000, 2'b00, "R6 repeat bit13");
      wr(2'b10, 16'h0000, 3'b000, 2'b00, "R5 clear bit13");
      wr(2'b01, 16'hFFFF, 3'b010, 2'b00, "R7 bit13 in disabled lane");
   endtask

   task automatic t_levels;
      wr(2'b10, 16'h8000, 3'b000, 2'b01, "R8 coin0 on");
      wr(2'b10, 16'h4000, 3'b000, 2'b10, "R8 coin1 on");
      wr(2'b01, 16'h0000, 3'b000, 2'b10, "R8 low write keeps levels");
      wr(2'b11, 16'hE003, 3'b111, 2'b11, "R5 R3 R4 full word");
   endtask

   task automatic t_no_strobe;
      wr_en = 1'b0; wr_be = 2'b11; wr_data = 16'h0000;
      @(negedge clk);
      check("R2 no strobe levels", {6'd0, lvl_out}, 8'h03);
      check("R2 no strobe pulses", {5'd0, act_pulse}, 8'd0);
      wr(2'b00, 16'h0000, 3'b000, 2'b11, "R2 no lanes enabled");
   endtask

   task automatic t_mid_reset;
      t_reset();
      wr(2'b10, 16'h2000, 3'b100, 2'b00, "R1 store cleared by reset");
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_low_lane();
      t_lane_gate();
      t_slave_reset();
      t_levels();
      t_no_strobe();
      t_mid_reset();
      finish_run();
   end

   initial begin
      #(8 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule